// File: doc/BRIEF.md
# Datapath ALU with Result Shifter

This block is the combinational arithmetic stage of a microprogrammed datapath. It takes a left operand from the holding register and a right operand from the shared operand bus. It combines them under a six-bit control field and passes the result through a small shifter. There are no opcodes. Every operation comes from independent control bits: a two-bit function select, one enable for each operand, an invert for the left operand and a carry-in. These bits together give pass-through, increment, decrement, subtraction, negation and the constants zero, one and minus one.

The block also produces negative and zero indications. Both are taken from the function unit's result before it is shifted, so the surrounding flag flip-flops can capture them at the same edge that loads the destination registers. All registers, including those flags, belong to the enclosing datapath.

Top module: `dp_alu_shifter`

## Requirements
- R1: The control field `fn_ctrl` is laid out as bits [5:4] function select, bit 3 left enable, bit 2 right enable, bit 1 left invert, bit 0 carry-in. A cleared enable makes that operand zero.
- R2: The left invert (bit 1) complements the left operand after enable gating, so a disabled and inverted left operand is all ones.
- R3: Function select 00 yields the bitwise AND of the prepared operands, and 01 yields their bitwise OR.
- R4: Function select 10 yields the complement of the prepared right operand. Function select 11 yields left + right + carry-in modulo 2^32, and the carry-out is discarded.
- R5: Shift code 10 (`sh_ctrl[1]` only) shifts the result left by 8 bits and fills with zeros.
- R6: Shift code 01 (`sh_ctrl[0]` only) shifts the result right by 1 bit and copies the sign bit into bit 31.
- R7: Shift codes 00 and 11 leave the result unshifted. Code 11 is illegal and is treated as no shift.
- R8: `n_out` equals bit 31 of the unshifted result and `z_out` is 1 exactly when the unshifted result is zero, whatever the shift code.
- R9: The control values give these results: 0x38 = A, 0x34 = B, 0x39 = A+1, 0x35 = B+1, 0x36 = B-1, 0x3F = B-A, 0x3B = -A, 0x10 = 0, 0x31 = 1, 0x32 = -1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 32 | Left operand from the holding register |
| b_in | input | 32 | Right operand from the operand bus |
| fn_ctrl | input | 6 | Function select, enables, left invert, carry-in |
| sh_ctrl | input | 2 | Shift code |
| y_out | output | 32 | Shifted result |
| n_out | output | 1 | Negative indication (unshifted result bit 31) |
| z_out | output | 1 | Zero indication (unshifted result is all zeros) |

## Verification
The in-line assertions assume that every input is a known two-state value whenever they are evaluated, and that all 64 control codes and all 4 shift codes are legal to present, including the illegal-by-convention shift code 11. The stimulus drives every input from the bench and changes inputs only just after a rising clock edge. It checks outputs at the falling edge, once the combinational paths have settled. The sweep covers every combination of function and shift code with random operands, so the flag and shift assertions see each code.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [1:0] {
      FN_AND  = 2'b00,
      FN_OR   = 2'b01,
      FN_NOTB = 2'b10,
      FN_ADD  = 2'b11
   } alu_fn_e;

   typedef enum logic [1:0] {
      SH_NONE = 2'b00,
      SH_SRA  = 2'b01,
      SH_SLL  = 2'b10,
      SH_BOTH = 2'b11
   } alu_sh_e;

   typedef struct packed {
      alu_fn_e fsel;
      logic    ena;
      logic    enb;
      logic    inva;
      logic    cin;
   } alu_ctrl_t;

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a_raw,
   input  logic [DATA_W-1:0] b_raw,
   input  logic              ena,
   input  logic              enb,
   input  logic              inva,
   output logic [DATA_W-1:0] a_op,
   output logic [DATA_W-1:0] b_op
);
   logic [DATA_W-1:0] a_gated;

   always_comb begin
      a_gated = ena ? a_raw : '0;
      a_op    = inva ? ~a_gated : a_gated;
      b_op    = enb ? b_raw : '0;
   end
endmodule

// File: rtl/alu_func_unit.sv
module alu_func_unit
   import alu_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDER_STYLE = 0
) (
   input  logic [DATA_W-1:0] a_op,
   input  logic [DATA_W-1:0] b_op,
   input  alu_fn_e           fsel,
   input  logic              cin,
   output logic [DATA_W-1:0] res,
   output logic              neg,
   output logic              zero
);
   logic [DATA_W-1:0] sum;

   generate
      if (ADDER_STYLE == 0) begin : g_add_infer
         always_comb sum = a_op + b_op + {{(DATA_W-1){1'b0}}, cin};
      end else if (ADDER_STYLE == 1) begin : g_add_ripple
         always_comb begin
            logic c;
            c = cin;
            for (int i = 0; i < DATA_W; i++) begin
               sum[i] = a_op[i] ^ b_op[i] ^ c;
               c      = (a_op[i] & b_op[i]) | (c & (a_op[i] ^ b_op[i]));
            end
         end
      end else begin : g_add_bad
         $error("alu_func_unit: ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   always_comb begin
      unique case (fsel)
         FN_AND:  res = a_op & b_op;
         FN_OR:   res = a_op | b_op;
         FN_NOTB: res = ~b_op;
         default: res = sum;
      endcase
      neg  = res[DATA_W-1];
      zero = ~|res;
   end

   always_comb begin
      if (fsel == FN_ADD && a_op == '0 && !cin)
         AST_ADD_IDENTITY: assert (res == b_op) else $error("add identity broken"); // R4
   end
endmodule

// File: rtl/alu_result_shifter.sv
module alu_result_shifter
   import alu_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SLL_AMT = 8,
   parameter int SRA_AMT = 1
) (
   input  logic [DATA_W-1:0] d_in,
   input  alu_sh_e           sh,
   output logic [DATA_W-1:0] d_out
);
   generate
      if (SLL_AMT < 1 || SLL_AMT >= DATA_W) begin : g_bad_sll
         $error("alu_result_shifter: SLL_AMT out of range");
      end
      if (SRA_AMT < 1 || SRA_AMT >= DATA_W) begin : g_bad_sra
         $error("alu_result_shifter: SRA_AMT out of range");
      end
   endgenerate

   always_comb begin
      unique case (sh)
         SH_SLL:  d_out = d_in << SLL_AMT;
         SH_SRA:  d_out = DATA_W'($signed(d_in) >>> SRA_AMT);
         default: d_out = d_in;
      endcase
   end

   always_comb begin
      if (sh == SH_SLL)
         AST_SLL_ZERO_FILL: assert (d_out[SLL_AMT-1:0] == '0) else $error("left shift fill"); // R5
      if (sh == SH_SRA)
         AST_SRA_SIGN_KEEP: assert (d_out[DATA_W-1] == d_in[DATA_W-1]) else $error("sign lost"); // R6
   end
endmodule

// File: rtl/dp_alu_shifter.sv
module dp_alu_shifter
   import alu_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int SLL_AMT     = 8,
   parameter int SRA_AMT     = 1,
   parameter int ADDER_STYLE = 0
) (
   input  logic [31:0] a_in,
   input  logic [31:0] b_in,
   input  logic [5:0]  fn_ctrl,
   input  logic [1:0]  sh_ctrl,
   output logic [31:0] y_out,
   output logic        n_out,
   output logic        z_out
);
   localparam int CTRL_W = $bits(alu_ctrl_t);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("dp_alu_shifter: port width fixed at 32");
      end
      if (CTRL_W != 6) begin : g_bad_ctrl
         $error("dp_alu_shifter: control field must be 6 bits");
      end
   endgenerate

   alu_ctrl_t         ctrl;
   alu_sh_e           sh;
   logic [DATA_W-1:0] a_op, b_op, alu_res;

   assign ctrl = alu_ctrl_t'(fn_ctrl);
   assign sh   = alu_sh_e'(sh_ctrl);

   alu_operand_prep #(.DATA_W(DATA_W)) u_prep (
      .a_raw (a_in),
      .b_raw (b_in),
      .ena   (ctrl.ena),
      .enb   (ctrl.enb),
      .inva  (ctrl.inva),
      .a_op  (a_op),
      .b_op  (b_op)
   );

   alu_func_unit #(.DATA_W(DATA_W), .ADDER_STYLE(ADDER_STYLE)) u_func (
      .a_op  (a_op),
      .b_op  (b_op),
      .fsel  (ctrl.fsel),
      .cin   (ctrl.cin),
      .res   (alu_res),
      .neg   (n_out),
      .zero  (z_out)
   );

   alu_result_shifter #(.DATA_W(DATA_W), .SLL_AMT(SLL_AMT), .SRA_AMT(SRA_AMT)) u_shift (
      .d_in  (alu_res),
      .sh    (sh),
      .d_out (y_out)
   );

   always_comb begin
      if (!ctrl.enb)
         AST_RIGHT_GATED: assert (b_op == '0) else $error("right gate"); // R1
      if (!ctrl.ena)
         AST_LEFT_GATED_INV: assert (a_op == (ctrl.inva ? {DATA_W{1'b1}} : '0)) else $error("left gate"); // R2
      if (sh == SH_NONE || sh == SH_BOTH) begin
         AST_NO_SHIFT_PASS: assert (y_out == alu_res) else $error("no-shift pass"); // R7
         AST_ZERO_FLAG: assert (z_out == (y_out == '0)) else $error("zero flag"); // R8
         AST_NEG_FLAG: assert (n_out == y_out[DATA_W-1]) else $error("neg flag"); // R8
      end
      if (sh == SH_SRA)
         AST_SRA_FLAG_SIGN: assert (y_out[DATA_W-1] == n_out) else $error("sra vs flag"); // R6
   end
endmodule

// File: tb/dp_alu_shifter_tb.sv
`timescale 1ns/1ps
module dp_alu_shifter_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] a_in, b_in;
   logic [5:0]  fn_ctrl;
   logic [1:0]  sh_ctrl;
   logic [31:0] y_out;
   logic        n_out, z_out;
   int          n_checks = 0;
   int          n_fail   = 0;
   bit          done     = 1'b0;

   always #2.5 clk = ~clk;

   dp_alu_shifter u_dut (
      .a_in(a_in), .b_in(b_in), .fn_ctrl(fn_ctrl), .sh_ctrl(sh_ctrl),
      .y_out(y_out), .n_out(n_out), .z_out(z_out)
   );

   // Behavioural reference written from the requirements.
   function automatic longint unsigned ref_alu(input int unsigned a, input int unsigned b,
                                               input int f);
      longint unsigned l, r, o;
      l = ((f >> 3) & 1) ? a : 0;
      if ((f >> 1) & 1) l = 64'hFFFF_FFFF - l;
      r = ((f >> 2) & 1) ? b : 0;
      case ((f >> 4) & 3)
         0: o = l & r;
         1: o = l | r;
         2: o = 64'hFFFF_FFFF - r;
         default: o = (l + r + (f & 1)) % 64'h1_0000_0000;
      endcase
      return o;
   endfunction

   function automatic int unsigned ref_shift(input int unsigned v, input int s);
      if (s == 2) return v * 256;
      if (s == 1) return (v / 2) + ((v >= 32'h8000_0000) ? 32'h8000_0000 : 0);
      return v;
   endfunction

   task automatic check(input string req, input int unsigned a, input int unsigned b,
                        input int f, input int s);
      int unsigned u, exp_y;
      bit exp_n, exp_z;
      @(posedge clk);
      #1;
      a_in = a; b_in = b; fn_ctrl = 6'(f); sh_ctrl = 2'(s);
      @(negedge clk);
      u     = int'(ref_alu(a, b, f));
      exp_y = ref_shift(u, s);
      exp_n = (u >= 32'h8000_0000);
      exp_z = (u == 0);
      n_checks++;
      if (y_out !== exp_y || n_out !== exp_n || z_out !== exp_z) begin
         n_fail++;
         $display("FAIL %s fn=%02h sh=%0d a=%08h b=%08h: got y=%08h n=%b z=%b exp y=%08h n=%b z=%b",
                  req, f, s, a, b, y_out, n_out, z_out, exp_y, exp_n, exp_z);
      end
   endtask

   task automatic expect_val(input string req, input int unsigned a, input int unsigned b,
                             input int f, input int unsigned want);
      @(posedge clk);
      #1;
      a_in = a; b_in = b; fn_ctrl = 6'(f); sh_ctrl = 2'b00;
      @(negedge clk);
      n_checks++;
      if (y_out !== want) begin
         n_fail++;
         $display("FAIL %s fn=%02h: got %08h exp %08h", req, f, y_out, want);
      end
   endtask

   initial begin
      a_in = '0; b_in = '0; fn_ctrl = '0; sh_ctrl = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // Reset state: all-zero inputs give AND of zeros
      @(negedge clk);
      n_checks++;
      if (y_out !== 32'h0 || z_out !== 1'b1 || n_out !== 1'b0) begin
         n_fail++;
         $display("FAIL R8 reset state: got y=%08h n=%b z=%b exp 0 0 1", y_out, n_out, z_out);
      end
      // R9 common combinations, A=0x1234_5678 B=0x0000_1000
      expect_val("R9 pass A", 32'h1234_5678, 32'h1000, 6'h38, 32'h1234_5678);
      expect_val("R9 pass B", 32'h1234_5678, 32'h1000, 6'h34, 32'h0000_1000);
      expect_val("R9 A+1",   32'h1234_5678, 32'h1000, 6'h39, 32'h1234_5679);
      expect_val("R9 B+1",   32'h1234_5678, 32'h1000, 6'h35, 32'h0000_1001);
      expect_val("R9 B-1",   32'h1234_5678, 32'h1000, 6'h36, 32'h0000_0FFF);
      expect_val("R9 B-A",   32'h0000_0005, 32'h0000_0003, 6'h3F, 32'hFFFF_FFFE);
      expect_val("R9 -A",    32'h0000_0001, 32'h1000, 6'h3B, 32'hFFFF_FFFF);
      expect_val("R9 zero",  32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'h10, 32'h0);
      expect_val("R9 one",   32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'h31, 32'h1);
      expect_val("R9 minus one", 32'h5555_AAAA, 32'h1, 6'h32, 32'hFFFF_FFFF);
      // R4 carry-out discarded
      expect_val("R4 wrap", 32'hFFFF_FFFF, 32'h0000_0001, 6'h3D, 32'h0000_0001);
      // R1 gating: AND with left disabled is zero
      expect_val("R1 left gated", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'h04, 32'h0);
      // R2 invert after gate: disabled+inverted left OR right gives all ones
      expect_val("R2 inv gated", 32'h0, 32'h0, 6'h12, 32'hFFFF_FFFF);
      // R3 AND / OR
      check("R3 and", 32'hF0F0_1234, 32'hFF00_FF00, 6'h0C, 0);
      check("R3 or",  32'hF0F0_1234, 32'h0F00_00FF, 6'h1C, 0);
      // R4 NOT B ignores A
      check("R4 notb", 32'hDEAD_BEEF, 32'h0F0F_0F0F, 6'h2F, 0);
      // R5/R6/R7 shifts on a negative result
      check("R5 sll8", 32'h8123_4567, 32'h0, 6'h38, 2);
      check("R6 sra1", 32'h8123_4567, 32'h0, 6'h38, 1);
      check("R6 sra1 pos", 32'h4123_4567, 32'h0, 6'h38, 1);
      check("R7 both", 32'h8123_4567, 32'h0, 6'h38, 3);
      // R8 flags from unshifted result: 0x0100_0000 << 8 is zero but Z stays 0
      check("R8 flag preshift", 32'h0100_0000, 32'h0, 6'h38, 2);
      check("R8 zero with sra", 32'h0, 32'h0, 6'h38, 1);
      // Sweep: every control code and shift code with random operands (R1..R8)
      for (int f = 0; f < 64; f++) begin
         for (int s = 0; s < 4; s++) begin
            check("R1-sweep", $urandom, $urandom, f, s);
            check("R8-sweep", 32'h8000_0000, 32'h8000_0000, f, s);
         end
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule